// File: doc/BRIEF.md
# Intermittent Halt Wake Controller

This block controls the internal halt state of a small microcontroller core. The core writes a one-bit run flag. A 0 stops the core and a 1 keeps it running. While the flag is clear, a registered clock-enable output to the core stays low. The crystal-domain timekeeping logic stays outside this block and keeps running through the halt.

A periodic overflow pulse from that timekeeping prescaler forces the run flag back to 1, which wakes the core. The core then runs a short routine, such as a clock update, and writes 0 to halt again. With a 16 Hz overflow source this gives a burst of activity about every 62.5 ms, and the core stays stopped in between.

An 8-bit wrapping counter records each wake event, meaning each overflow that arrives while the core is halted. A test environment can compare this count with the number of elapsed prescaler periods. Every pin is a plain control or status signal. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, `run_flag` is 1, `core_clk_en` is 1 and `wake_count` is 0.
- R2: A write (`flag_wr`=1) with `flag_wdata`=0, with no overflow in that cycle, clears `run_flag` at the next clock edge.
- R3: A write with `flag_wdata`=1 sets `run_flag` at the next clock edge.
- R4: An `ovf_pulse` high in a cycle sets `run_flag` at the next clock edge, whatever its previous value.
- R5: When a write of 0 and `ovf_pulse` occur in the same cycle, `run_flag` becomes 1, so no wake-up is lost.
- R6: `core_clk_en` is a register that takes the value `run_flag` had before the same edge, so it follows the flag one cycle later and changes only on clock edges.
- R7: An `ovf_pulse` seen while `run_flag` is 0 increments `wake_count` by 1 at the next edge, and the count wraps from 255 to 0.
- R8: `wake_count` is unchanged by an overflow while `run_flag` is 1, by writes, and by idle cycles.
- R9: With neither a write nor an overflow, `run_flag` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (always running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_wr | input | 1 | Core write strobe for the run flag |
| flag_wdata | input | 1 | Value written: 0 halts, 1 runs |
| ovf_pulse | input | 1 | One-cycle prescaler overflow (wake source) |
| core_clk_en | output | 1 | Registered clock enable to the core |
| run_flag | output | 1 | Current run/halt flag |
| wake_count | output | 8 | Wrapping count of wake events |

## Verification
`run_flag` and `wake_count` respond at the first clock edge after the cycle in which a write or overflow is presented. `core_clk_en` responds one edge later than `run_flag`. The bench presents each stimulus for exactly one cycle, set up at the falling edge. For every cycle it pushes the predicted post-edge values into a queue. A monitor pops one entry 2 ns after each rising edge and compares it, so every result is checked in the cycle it is due. The expected `core_clk_en` is the model's flag value from before that edge.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
  localparam int unsigned WAKE_CNT_W = 8;
  typedef logic [WAKE_CNT_W-1:0] wake_cnt_t;
  localparam logic FLAG_RUN  = 1'b1;
  localparam logic FLAG_HALT = 1'b0;
endpackage

// File: rtl/hw_run_latch.sv
module hw_run_latch
  import halt_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic ovf_i,
  output logic run_o,
  output logic en_o
);
  logic run_q, run_d, en_q;

  // overflow set has priority over a software clear
  always_comb begin
    run_d = run_q;
    if (ovf_i)     run_d = FLAG_RUN;
    else if (wr_i) run_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= FLAG_RUN;
      en_q  <= 1'b1;
    end else begin
      run_q <= run_d;
      en_q  <= run_q;
    end
  end

  assign run_o = run_q;
  assign en_o  = en_q;

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> run_o); // R4
  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wdata_i && !ovf_i) |=> !run_o); // R2
  AST_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i) |=> run_o); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !ovf_i) |=> $stable(run_o)); // R9
endmodule

// File: rtl/hw_wake_counter.sv
module hw_wake_counter
  import halt_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ovf_i,
  input  logic      run_i,
  output wake_cnt_t count_o
);
  wake_cnt_t cnt_q;
  logic      wake_ev;

  assign wake_ev = ovf_i && (run_i == FLAG_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wake_ev) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_WAKE_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && !run_i) |=> (count_o == wake_cnt_t'($past(count_o) + 1'b1))); // R7
  AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_i && !run_i) |=> $stable(count_o)); // R8
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flag_wr,
  input  logic       flag_wdata,
  input  logic       ovf_pulse,
  output logic       core_clk_en,
  output logic       run_flag,
  output logic [7:0] wake_count
);
  logic      run_w;
  wake_cnt_t cnt_w;

  hw_run_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (flag_wr),
    .wdata_i (flag_wdata),
    .ovf_i   (ovf_pulse),
    .run_o   (run_w),
    .en_o    (core_clk_en)
  );

  hw_wake_counter u_wake_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf_i   (ovf_pulse),
    .run_i   (run_w),
    .count_o (cnt_w)
  );

  assign run_flag   = run_w;
  assign wake_count = cnt_w;

  AST_SAME_CYCLE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata && ovf_pulse) |=> run_flag); // R5
  AST_HALT_GATES_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_flag) |=> !core_clk_en); // R6
endmodule

// File: tb/halt_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag_wr = 1'b0, flag_wdata = 1'b0, ovf_pulse = 1'b0;
  logic core_clk_en, run_flag;
  logic [7:0] wake_count;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic       m_run = 1'b1;
  logic [7:0] m_cnt = 8'd0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  halt_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .ovf_pulse(ovf_pulse), .core_clk_en(core_clk_en), .run_flag(run_flag),
    .wake_count(wake_count)
  );

  function automatic void compare(input logic [9:0] exp, input string tag);
    logic [9:0] act;
    act = {core_clk_en, run_flag, wake_count};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: en/run/count actual %b/%b/%0d expected %b/%b/%0d",
               tag, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
    end
  endfunction

  // driver: one stimulus cycle, expected result pushed to the scoreboard
  task automatic step(input logic wr, input logic d, input logic ov, input string tag);
    logic nrun;
    logic [7:0] ncnt;
    @(negedge clk);
    flag_wr = wr; flag_wdata = d; ovf_pulse = ov;
    nrun = ov ? 1'b1 : (wr ? d : m_run);
    ncnt = (ov && !m_run) ? m_cnt + 8'd1 : m_cnt;
    exp_q.push_back({m_run, nrun, ncnt});
    tag_q.push_back(tag);
    m_run = nrun;
    m_cnt = ncnt;
  endtask

  // monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;  // R1 reset state
    if ({core_clk_en, run_flag, wake_count} !== 10'b11_0000_0000) begin
      n_bad++;
      $display("FAIL R1: actual %b/%b/%0d expected 1/1/0", core_clk_en, run_flag, wake_count);
    end
    rst_n = 1'b1;
    step(0, 0, 0, "R9 idle hold running");
    step(0, 0, 1, "R8 ovf while running");
    step(1, 0, 0, "R2 write 0 halts");
    step(0, 0, 0, "R6 enable follows halt");
    step(0, 0, 0, "R9 idle hold halted");
    step(0, 1, 0, "R9 data without strobe ignored");
    step(0, 0, 1, "R4 R7 ovf wakes");
    step(0, 0, 0, "R6 enable follows wake");
    step(1, 0, 0, "R2 halt again");
    step(1, 1, 0, "R3 write 1 runs");
    step(0, 0, 0, "R8 count unchanged by write");
    step(1, 0, 0, "R2 halt");
    step(1, 0, 1, "R5 same-cycle set wins");
    step(0, 0, 0, "R6 enable stays high");
    step(1, 1, 1, "R8 ovf plus write 1 while running");
    // burst pattern: halt, wake, run a routine, repeated until the count wraps
    for (int i = 0; i < 256; i++) begin
      step(1, 0, 0, "R2 burst halt");
      step(0, 0, 0, "R9 burst wait");
      step(0, 0, 1, "R7 burst wake");
      step(0, 0, 0, "R6 burst run");
    end
    step(0, 0, 0, "R7 wrapped count");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule